// File: doc/BRIEF.md
# Two-Slot TDM Audio Serial Port (Slave Mode)

This block links a system-clocked datapath to an external audio converter that owns the serial timing. The converter drives the bit clock and a one-bit frame marker. The port only follows these two signals and never generates them. Each frame is 32 bit clocks long and holds two 16-bit slots. The first slot carries the left channel and the second the right, in both directions. Serial bits travel most significant bit first. Outgoing bits change on the rising bit-clock edge, and incoming bits are captured on the falling edge.

All three serial inputs are oversampled by the system clock through a synchronizer chain. Bit-clock edges are then detected in the system-clock domain. On the parallel side, each 16-bit slot occupies bits 23..8 of a 24-bit word:

- **Receive:** the low byte of each received word reads as zero. Both received words are published together with a one-cycle strobe.
- **Transmit:** the low byte of each transmit word is ignored. The two transmit words are captured at the start of each frame and held for the whole frame.
- **Error flags:** sticky flags report a received frame that was never acknowledged (overrun) and a frame that started without fresh transmit data (underrun). Each flag has its own clear input.

Top module: `tdm_audio_port`

## Requirements
- R1: The port takes its framing only from the incoming frame marker. The marker is high for one bit clock. The bit clock after the one in which the marker is high carries the MSB of the left slot.
- R2: Received bits are captured on falling bit-clock edges, MSB first. Slot 0 is left and slot 1 is right. `rx_left` and `rx_right` equal `{slot[15:0], 8'h00}`.
- R3: `txd` changes only after a rising bit-clock edge, MSB first. Slot 0 sends `tx_left[23:8]` and slot 1 sends `tx_right[23:8]`. Bits 7..0 of both transmit words have no effect on `txd`.
- R4: The transmit words are captured at the first rising edge of each frame. Changes to `tx_left` or `tx_right` later in the frame do not alter the bits sent in that frame.
- R5: `rx_valid` is high for exactly one system clock after bit 31 of each complete frame is captured. `rx_left` and `rx_right` are updated together at that point and hold until the next complete frame.
- R6: After bit 31, the bit position returns to the left slot even if no frame marker was seen. The next 32 bits are then received and transmitted as a normal frame.
- R7: A frame marker seen in the middle of a frame restarts the bit position, so the next bit is the left MSB. The interrupted frame gives no `rx_valid`.
- R8: When a frame completes while the previous one has not been acknowledged with `rx_ack`, the sticky `overrun` flag is set. `clr_ovr` clears it in the next cycle and takes priority over a new overrun.
- R9: When a frame's transmit words are captured with no `tx_write` pulse since the previous capture, the sticky `underrun` flag is set. `clr_unr` clears it in the next cycle and takes priority.
- R10: After reset, `rx_left`, `rx_right`, `rx_valid`, `txd`, `overrun` and `underrun` are 0. Bits received before the first frame marker produce no `rx_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| bclk | input | 1 | Bit clock from the converter |
| fsync | input | 1 | Frame marker from the converter, high for one bit clock before slot 0 |
| rxd | input | 1 | Serial receive data |
| txd | output | 1 | Serial transmit data |
| rx_left | output | 24 | Last received left sample, slot in bits 23..8 |
| rx_right | output | 24 | Last received right sample, slot in bits 23..8 |
| rx_valid | output | 1 | One-cycle strobe when a received frame is complete |
| rx_ack | input | 1 | Consumer has read the received pair |
| tx_left | input | 24 | Left sample to send, bits 23..8 used |
| tx_right | input | 24 | Right sample to send, bits 23..8 used |
| tx_write | input | 1 | Pulse: fresh transmit samples are present |
| overrun | output | 1 | Sticky: a frame completed while the previous one was unread |
| underrun | output | 1 | Sticky: a frame started without fresh transmit samples |
| clr_ovr | input | 1 | Clears `overrun` |
| clr_unr | input | 1 | Clears `underrun` |

## Verification
The bench goes after slot alignment around the marker. A port that is off by one bit would show every received and sent word shifted, with the LSB of the other slot pulled in. It also drives:

- a frame that ends without a marker, where a counter that does not wrap would lose the following frame;
- a marker at bit 9, where a port that ignores it would deliver a mangled pair or a spurious strobe;
- a mid-frame change of the transmit words and padding bytes set to non-zero values, which catch capture at the wrong moment or leakage of the low byte;
- flag sequences that catch a flag that is not sticky, a clear that loses to a new event, and a flag raised on a normal acknowledged stream.

// File: rtl/tdm_pkg.sv
package tdm_pkg;
   localparam int TDM_NUM_SLOTS = 2;
   localparam int PIN_BCLK      = 0;
   localparam int PIN_FS        = 1;
   localparam int PIN_RXD       = 2;
   localparam int PIN_COUNT     = 3;
endpackage

// File: rtl/tdm_pin_sync.sv
module tdm_pin_sync
   import tdm_pkg::*;
#(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bclk,
   input  logic fsync,
   input  logic rxd,
   output logic bit_rise,
   output logic bit_fall,
   output logic fs_s,
   output logic rxd_s
);
   localparam int LAST = STAGES - 1;

   logic [PIN_COUNT-1:0] stg [STAGES];
   logic                 bclk_q;

   always_ff @(posedge clk) begin
      if (!rst_n) stg[0] <= '0;
      else        stg[0] <= {rxd, fsync, bclk};
   end

   for (genvar i = 1; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) stg[i] <= '0;
         else        stg[i] <= stg[i-1];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) bclk_q <= 1'b0;
      else        bclk_q <= stg[LAST][PIN_BCLK];
   end

   assign bit_rise = stg[LAST][PIN_BCLK] & ~bclk_q;
   assign bit_fall = ~stg[LAST][PIN_BCLK] & bclk_q;
   assign fs_s     = stg[LAST][PIN_FS];
   assign rxd_s    = stg[LAST][PIN_RXD];
endmodule

// File: rtl/tdm_rx_deser.sv
module tdm_rx_deser
   import tdm_pkg::*;
#(
   parameter int SLOT_W = 16,
   parameter int WORD_W = 24
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_fall,
   input  logic              fs_s,
   input  logic              rxd_s,
   input  logic              rx_ack,
   input  logic              clr_ovr,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid,
   output logic              overrun,
   output logic              frame_start
);
   localparam int FRAME = TDM_NUM_SLOTS * SLOT_W;
   localparam int CW    = $clog2(FRAME);
   localparam int PAD   = WORD_W - SLOT_W;

   logic              armed;
   logic              pending;
   logic [CW-1:0]     cnt;
   logic [SLOT_W-1:0] sh;
   logic [SLOT_W-1:0] left_hold;
   logic [SLOT_W-1:0] sh_next;
   logic              last_bit;
   logic              mid_slot;
   logic              word_done;

   assign sh_next     = {sh[SLOT_W-2:0], rxd_s};
   assign last_bit    = (cnt == CW'(FRAME - 1));
   assign mid_slot    = (cnt == CW'(SLOT_W - 1));
   assign word_done   = bit_fall & armed & last_bit;
   assign frame_start = bit_fall & (fs_s | (armed & last_bit));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed     <= 1'b0;
         cnt       <= '0;
         sh        <= '0;
         left_hold <= '0;
         rx_left   <= '0;
         rx_right  <= '0;
         rx_valid  <= 1'b0;
         pending   <= 1'b0;
         overrun   <= 1'b0;
      end else begin
         rx_valid <= word_done;
         if (bit_fall) begin
            if (armed) begin
               sh <= sh_next;
               if (mid_slot) left_hold <= sh_next;
            end
            if (fs_s) begin
               cnt   <= '0;
               armed <= 1'b1;
            end else if (armed) begin
               cnt <= last_bit ? '0 : cnt + 1'b1;
            end
         end
         if (word_done) begin
            rx_left  <= WORD_W'(left_hold) << PAD;
            rx_right <= WORD_W'(sh_next) << PAD;
         end
         pending <= word_done | (pending & ~rx_ack);
         if (clr_ovr)                             overrun <= 1'b0;
         else if (word_done & pending & ~rx_ack)  overrun <= 1'b1;
      end
   end

   assert_valid_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |=> !rx_valid);
   assert_valid_after_sync_R10: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid |-> $past(armed));
   assert_ovr_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !clr_ovr) |=> overrun);
   assert_ovr_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
      clr_ovr |=> !overrun);
endmodule

// File: rtl/tdm_tx_ser.sv
module tdm_tx_ser
   import tdm_pkg::*;
#(
   parameter int SLOT_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_rise,
   input  logic              frame_start,
   input  logic [SLOT_W-1:0] slot_left,
   input  logic [SLOT_W-1:0] slot_right,
   input  logic              tx_write,
   input  logic              clr_unr,
   output logic              txd,
   output logic              underrun
);
   localparam int FRAME = TDM_NUM_SLOTS * SLOT_W;

   logic             pend;
   logic             fresh;
   logic             load;
   logic [FRAME-1:0] sh;
   logic [FRAME-1:0] frame_word;

   assign load       = bit_rise & pend;
   assign frame_word = {slot_left, slot_right};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend     <= 1'b0;
         fresh    <= 1'b0;
         sh       <= '0;
         txd      <= 1'b0;
         underrun <= 1'b0;
      end else begin
         if (frame_start)   pend <= 1'b1;
         else if (bit_rise) pend <= 1'b0;
         if (bit_rise) begin
            if (pend) begin
               txd <= frame_word[FRAME-1];
               sh  <= frame_word << 1;
            end else begin
               txd <= sh[FRAME-1];
               sh  <= sh << 1;
            end
         end
         fresh <= tx_write | (fresh & ~load);
         if (clr_unr)              underrun <= 1'b0;
         else if (load & ~fresh)   underrun <= 1'b1;
      end
   end

   assert_txd_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(txd) |-> $past(bit_rise));
   assert_unr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (underrun && !clr_unr) |=> underrun);
   assert_unr_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
      clr_unr |=> !underrun);
endmodule

// File: rtl/tdm_audio_port.sv
module tdm_audio_port
   import tdm_pkg::*;
#(
   parameter int SLOT_W      = 16,
   parameter int WORD_W      = 24,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bclk,
   input  logic              fsync,
   input  logic              rxd,
   output logic              txd,
   output logic [WORD_W-1:0] rx_left,
   output logic [WORD_W-1:0] rx_right,
   output logic              rx_valid,
   input  logic              rx_ack,
   input  logic [WORD_W-1:0] tx_left,
   input  logic [WORD_W-1:0] tx_right,
   input  logic              tx_write,
   output logic              overrun,
   output logic              underrun,
   input  logic              clr_ovr,
   input  logic              clr_unr
);
   if (WORD_W < SLOT_W) begin : g_bad_word
      $error("WORD_W must be at least SLOT_W");
   end
   if (SLOT_W < 2) begin : g_bad_slot
      $error("SLOT_W must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic bit_rise, bit_fall, fs_s, rxd_s, frame_start;

   tdm_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rxd(rxd),
      .bit_rise(bit_rise), .bit_fall(bit_fall), .fs_s(fs_s), .rxd_s(rxd_s)
   );

   tdm_rx_deser #(.SLOT_W(SLOT_W), .WORD_W(WORD_W)) u_rx (
      .clk(clk), .rst_n(rst_n), .bit_fall(bit_fall), .fs_s(fs_s), .rxd_s(rxd_s),
      .rx_ack(rx_ack), .clr_ovr(clr_ovr), .rx_left(rx_left), .rx_right(rx_right),
      .rx_valid(rx_valid), .overrun(overrun), .frame_start(frame_start)
   );

   tdm_tx_ser #(.SLOT_W(SLOT_W)) u_tx (
      .clk(clk), .rst_n(rst_n), .bit_rise(bit_rise), .frame_start(frame_start),
      .slot_left(tx_left[WORD_W-1 -: SLOT_W]), .slot_right(tx_right[WORD_W-1 -: SLOT_W]),
      .tx_write(tx_write), .clr_unr(clr_unr), .txd(txd), .underrun(underrun)
   );
endmodule

// File: tb/tdm_audio_port_bench.sv
`timescale 1ns/1ps
module tdm_audio_port_bench;
   localparam time CLK_P = 5ns;
   localparam time HALF  = 40ns;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bclk = 1'b0, fsync = 1'b0, rxd = 1'b0;
   logic txd;
   logic [23:0] rx_left, rx_right, tx_left = '0, tx_right = '0;
   logic rx_valid, rx_ack = 1'b0, tx_write = 1'b0;
   logic overrun, underrun, clr_ovr = 1'b0, clr_unr = 1'b0;

   int checks = 0, fails = 0, vcnt = 0, exp_v = 0;
   bit done = 1'b0;
   logic [31:0] cap;

   // rl, rr, tl, tr
   localparam logic [63:0] VEC [4] = '{
      64'h8001_7FFE_A5C3_1234,
      64'hFFFF_0000_0001_8000,
      64'h1234_ABCD_FFFF_FFFF,
      64'h0F0F_F0F0_5AA5_C33C
   };

   always #(CLK_P/2) clk = ~clk;

   tdm_audio_port u_tdm_audio_port (
      .clk(clk), .rst_n(rst_n), .bclk(bclk), .fsync(fsync), .rxd(rxd), .txd(txd),
      .rx_left(rx_left), .rx_right(rx_right), .rx_valid(rx_valid), .rx_ack(rx_ack),
      .tx_left(tx_left), .tx_right(tx_right), .tx_write(tx_write),
      .overrun(overrun), .underrun(underrun), .clr_ovr(clr_ovr), .clr_unr(clr_unr)
   );

   always @(negedge clk) if (rx_valid) vcnt++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic pulse(ref logic s);
      @(negedge clk) s = 1'b1;
      @(negedge clk) s = 1'b0;
   endtask

   task automatic run_frame(input logic [15:0] rl, rr, tl, tr, input int nbits,
                            input bit fs_end, input bit do_write, input bit do_ack,
                            input bit mid_change);
      logic [31:0] d;
      d = {rl, rr};
      tx_left  = {tl, 8'hA5};
      tx_right = {tr, 8'h5A};
      if (do_write) pulse(tx_write);
      for (int i = 0; i < nbits; i++) begin
         bclk  = 1'b1;
         rxd   = d[31-i];
         fsync = fs_end && (i == nbits - 1);
         #HALF;
         cap[31-i] = txd;
         if (mid_change && i == 5) begin
            tx_left  = ~tx_left;
            tx_right = ~tx_right;
         end
         bclk = 1'b0;
         #HALF;
      end
      fsync = 1'b0;
      if (do_ack) pulse(rx_ack);
   endtask

   task automatic full_check(input string tag, input logic [15:0] rl, rr, tl, tr);
      check({tag, " rx_left"},  {8'h0, rx_left},  {8'h0, rl, 8'h00});
      check({tag, " rx_right"}, {8'h0, rx_right}, {8'h0, rr, 8'h00});
      check({tag, " tx bits"},  cap, {tl, tr});
      check({tag, " valid count"}, vcnt, exp_v);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   endtask

   initial begin
      #(CLK_P * 200000);
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      finish_run();
   end

   initial begin
      #1.3ns;
      repeat (5) @(negedge clk);
      // R10 reset state
      check("R10 reset rx_left", {8'h0, rx_left}, 0);
      check("R10 reset txd/valid/flags", {rx_valid, txd, overrun, underrun}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      // R10 bits before first marker are ignored
      run_frame(16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 8, 0, 0, 1, 0);
      check("R10 no valid before sync", vcnt, 0);
      check("R10 rx_left unchanged before sync", {8'h0, rx_left}, 0);
      // R1 sync bit
      run_frame(16'h0, 16'h0, 16'h0, 16'h0, 1, 1, 1, 1, 0);

      // table walk, R1 R2 R3 R5
      for (int v = 0; v < 4; v++) begin
         run_frame(VEC[v][63:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0], 32, 1, 1, 1, 0);
         exp_v++;
         full_check("R1 R2 R3 R5 vec", VEC[v][63:48], VEC[v][47:32], VEC[v][31:16], VEC[v][15:0]);
      end
      check("R8 R9 no flags on clean stream", {overrun, underrun}, 0);

      // R4 mid-frame change of transmit words
      run_frame(16'h1111, 16'h2222, 16'hC0DE, 16'hBEEF, 32, 1, 1, 1, 1);
      exp_v++;
      check("R4 held tx bits", cap, 32'hC0DE_BEEF);
      run_frame(16'h3333, 16'h4444, 16'h0F1E, 16'h2D3C, 32, 1, 1, 1, 0);
      exp_v++;
      full_check("R4 next frame", 16'h3333, 16'h4444, 16'h0F1E, 16'h2D3C);

      // R6 frame without marker, then one after the wrap
      run_frame(16'hAAAA, 16'h5555, 16'h1357, 16'h2468, 32, 0, 1, 1, 0);
      exp_v++;
      full_check("R6 no-marker frame", 16'hAAAA, 16'h5555, 16'h1357, 16'h2468);
      run_frame(16'h6789, 16'h9876, 16'hFEDC, 16'h0123, 32, 1, 1, 1, 0);
      exp_v++;
      full_check("R6 wrapped frame", 16'h6789, 16'h9876, 16'hFEDC, 16'h0123);

      // R7 marker at bit 9
      run_frame(16'hFFFF, 16'hFFFF, 16'h0, 16'h0, 10, 1, 1, 1, 0);
      check("R7 no valid on cut frame", vcnt, exp_v);
      run_frame(16'h4321, 16'h8765, 16'h9ABC, 16'hDEF0, 32, 1, 1, 1, 0);
      exp_v++;
      full_check("R7 resynced frame", 16'h4321, 16'h8765, 16'h9ABC, 16'hDEF0);

      // R8 overrun
      run_frame(16'h0101, 16'h0202, 16'h0, 16'h0, 32, 1, 1, 0, 0);
      check("R8 no overrun yet", overrun, 0);
      run_frame(16'h0303, 16'h0404, 16'h0, 16'h0, 32, 1, 1, 1, 0);
      check("R8 overrun set", overrun, 1);
      run_frame(16'h0505, 16'h0606, 16'h0, 16'h0, 32, 1, 1, 1, 0);
      check("R8 overrun sticky", overrun, 1);
      pulse(clr_ovr);
      @(negedge clk);
      check("R8 overrun cleared", overrun, 0);
      exp_v += 3;

      // R9 underrun
      run_frame(16'h0, 16'h0, 16'h7777, 16'h8888, 32, 1, 1, 1, 0);
      check("R9 no underrun yet", underrun, 0);
      run_frame(16'h0, 16'h0, 16'h7777, 16'h8888, 32, 1, 0, 1, 0);
      run_frame(16'h0, 16'h0, 16'h9999, 16'hAAAA, 32, 1, 1, 1, 0);
      check("R9 underrun set and sticky", underrun, 1);
      pulse(clr_unr);
      @(negedge clk);
      check("R9 underrun cleared", underrun, 0);
      exp_v += 3;
      check("R5 final valid count", vcnt, exp_v);
      finish_run();
   end
endmodule